// File: doc/BRIEF.md
# One-Day Watch With Alarm

This block keeps the time of day as hours, minutes and seconds and returns to midnight once per day. An internal prescaler divides a base tick input down to one step per second. Software writes the watch and an alarm time one byte at a time through a small address space, and every stored field can be read back on output ports. Each time the watch steps forward, the new time is compared with the alarm. On a match with a valid alarm, a one-cycle alarm event pulse goes out. A neighbouring status block uses this pulse to set its alarm flag and drive the change-information line.

Written bytes are sanitized as they are stored. Bits above the field width are dropped. A watch hour above 23 is held at 23. An alarm field is stored exactly as masked, and any alarm field beyond its range turns the alarm off. Alarm event handling is a three-state machine. `ALM_OFF` means the alarm fields are out of range. `ALM_ARMED` means the alarm is valid and waiting. `ALM_FIRE` is the one cycle in which the event is driven. The state moves to `ALM_FIRE` from any state when a compare strobe sees a valid, matching alarm. Otherwise it moves to `ALM_ARMED` when the fields are valid and to `ALM_OFF` when they are not. `ALM_FIRE` always leaves after one cycle by the same rules.

Top module: `owd_watch`

## Requirements
- R1: After reset the watch reads 00:00:00, the alarm reads hours 31, minutes 63, seconds 63, `alarm_armed` is 0 and `alarm_evt` is 0.
- R2: With no watch write, the watch advances by one second on every TICKS_PER_SEC-th `base_tick`. The change is visible after the clock edge that samples that tick.
- R3: The seconds field returns to 0 and carries into minutes when it is 59 or more. Minutes do the same into hours. Hours return to 0 when they are 23 or more, so 23:59:59 is followed by 00:00:00.
- R4: A write stores only `wr_data[4:0]` for an hours field and `wr_data[5:0]` for a minutes or seconds field. For example, 70 stores 6 and 81 stores 17.
- R5: A watch-hours write whose masked value is above 23 stores 23. An alarm-hours write stores the masked value unchanged, for example 25.
- R6: `wr_addr` selects the field written on a clock edge with `wr_en` high. The map is 2 = alarm hours, 3 = alarm minutes, 4 = alarm seconds, 5 = watch hours, 6 = watch minutes, 7 = watch seconds. Addresses 0 and 1 change nothing.
- R7: `alarm_armed` is 1 exactly when the stored alarm hours are at most 23, the minutes at most 59 and the seconds at most 59.
- R8: `alarm_evt` is high for exactly one cycle. This is the cycle after the edge where the watch advanced to a time equal to the stored alarm while that alarm is armed. A single match gives a single pulse.
- R9: A write to any watch byte stops the advance on that edge. A watch value that equals the alarm because it was written, not counted, raises no event.
- R10: A watch-seconds write clears the prescaler, so the next advance comes after a full TICKS_PER_SEC further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle timebase pulse, TICKS_PER_SEC per second |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Field select for a write |
| wr_data | input | 8 | Write byte |
| watch_hr | output | 5 | Watch hours |
| watch_min | output | 6 | Watch minutes |
| watch_sec | output | 6 | Watch seconds |
| alarm_hr | output | 5 | Stored alarm hours |
| alarm_min | output | 6 | Stored alarm minutes |
| alarm_sec | output | 6 | Stored alarm seconds |
| alarm_armed | output | 1 | Alarm fields are all in range |
| alarm_evt | output | 1 | One-cycle alarm match pulse |

## Verification
A corrupted prescaler count shows up at the watch seconds port on the very next advance. That advance comes early or late by as many ticks as the count is wrong. A wrong carry or clamp in the counter is visible within one second step, because all three fields are brought out on ports and compared every cycle. A wrong alarm state shows up either as an event that is missing or repeated in the cycle after a matching advance, or as a wrong armed flag in the cycle after an alarm write. Running the reference model in lockstep catches each of these on the first cycle it appears.

// File: rtl/owd_pkg.sv
`timescale 1ns/1ps
package owd_pkg;
    localparam int HR_W   = 5;
    localparam int MS_W   = 6;
    localparam int HR_TOP = 23;
    localparam int MS_TOP = 59;

    typedef struct packed {
        logic [HR_W-1:0] hr;
        logic [MS_W-1:0] mn;
        logic [MS_W-1:0] sc;
    } tod_t;

    typedef enum logic [2:0] {
        ADR_ALM_HR = 3'd2,
        ADR_ALM_MN = 3'd3,
        ADR_ALM_SC = 3'd4,
        ADR_WCH_HR = 3'd5,
        ADR_WCH_MN = 3'd6,
        ADR_WCH_SC = 3'd7
    } fld_adr_t;

    typedef enum logic [1:0] {
        ALM_OFF   = 2'd0,
        ALM_ARMED = 2'd1,
        ALM_FIRE  = 2'd2
    } alm_state_t;
endpackage

// File: rtl/owd_prescaler.sv
`timescale 1ns/1ps
module owd_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    input  logic clr,
    output logic sec_step
);
    localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

    logic [PW-1:0] cnt;

    assign sec_step = base_tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (base_tick)
            cnt <= sec_step ? '0 : cnt + PW'(1);
    end

    AST_PRESC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (cnt == '0)); // R10
endmodule

// File: rtl/owd_time_counter.sv
`timescale 1ns/1ps
module owd_time_counter
    import owd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       wr_hr,
    input  logic       wr_mn,
    input  logic       wr_sc,
    input  logic [7:0] wr_data,
    output tod_t       tod,
    output logic       advanced
);
    localparam logic [HR_W-1:0] HR_LIM = HR_W'(HR_TOP);
    localparam logic [MS_W-1:0] MS_LIM = MS_W'(MS_TOP);

    logic       any_wr;
    logic [HR_W-1:0] hr_masked;
    tod_t       nxt;

    assign any_wr    = wr_hr || wr_mn || wr_sc;
    assign advanced  = step && !any_wr;
    assign hr_masked = wr_data[HR_W-1:0];

    always_comb begin
        nxt = tod;
        if (any_wr) begin
            if (wr_hr) nxt.hr = (hr_masked > HR_LIM) ? HR_LIM : hr_masked;
            if (wr_mn) nxt.mn = wr_data[MS_W-1:0];
            if (wr_sc) nxt.sc = wr_data[MS_W-1:0];
        end else if (step) begin
            if (tod.sc >= MS_LIM) begin
                nxt.sc = '0;
                if (tod.mn >= MS_LIM) begin
                    nxt.mn = '0;
                    nxt.hr = (tod.hr >= HR_LIM) ? '0 : tod.hr + HR_W'(1);
                end else begin
                    nxt.mn = tod.mn + MS_W'(1);
                end
            end else begin
                nxt.sc = tod.sc + MS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tod <= '0;
        else        tod <= nxt;
    end

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(advanced) && $past(tod.sc) < MS_LIM) |-> (tod.sc == $past(tod.sc) + MS_W'(1))); // R2
    AST_HOUR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tod.hr <= HR_LIM); // R5
    AST_HOLD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_hr) && !$past(wr_mn) && !$past(wr_sc)) |-> (tod.sc == $past(tod.sc))); // R9
endmodule

// File: rtl/owd_alarm_reg.sv
`timescale 1ns/1ps
module owd_alarm_reg
    import owd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hr,
    input  logic       wr_mn,
    input  logic       wr_sc,
    input  logic [7:0] wr_data,
    output tod_t       alm,
    output logic       fields_ok
);
    assign fields_ok = (alm.hr <= HR_W'(HR_TOP)) &&
                       (alm.mn <= MS_W'(MS_TOP)) &&
                       (alm.sc <= MS_W'(MS_TOP));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm <= '{hr: '1, mn: '1, sc: '1};
        end else begin
            if (wr_hr) alm.hr <= wr_data[HR_W-1:0];
            if (wr_mn) alm.mn <= wr_data[MS_W-1:0];
            if (wr_sc) alm.sc <= wr_data[MS_W-1:0];
        end
    end

    AST_ALM_HR_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_hr) |-> (alm.hr == $past(wr_data[HR_W-1:0]))); // R5
endmodule

// File: rtl/owd_watch.sv
`timescale 1ns/1ps
module owd_watch
    import owd_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [4:0] watch_hr,
    output logic [5:0] watch_min,
    output logic [5:0] watch_sec,
    output logic [4:0] alarm_hr,
    output logic [5:0] alarm_min,
    output logic [5:0] alarm_sec,
    output logic       alarm_armed,
    output logic       alarm_evt
);
    logic w_ahr, w_amn, w_asc, w_whr, w_wmn, w_wsc;
    logic sec_step, advanced, fields_ok, chk_q, hit;
    tod_t tod, alm;
    alm_state_t state, state_nxt;

    assign w_ahr = wr_en && (wr_addr == ADR_ALM_HR);
    assign w_amn = wr_en && (wr_addr == ADR_ALM_MN);
    assign w_asc = wr_en && (wr_addr == ADR_ALM_SC);
    assign w_whr = wr_en && (wr_addr == ADR_WCH_HR);
    assign w_wmn = wr_en && (wr_addr == ADR_WCH_MN);
    assign w_wsc = wr_en && (wr_addr == ADR_WCH_SC);

    owd_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .clr(w_wsc), .sec_step(sec_step)
    );

    owd_time_counter u_count (
        .clk(clk), .rst_n(rst_n), .step(sec_step),
        .wr_hr(w_whr), .wr_mn(w_wmn), .wr_sc(w_wsc), .wr_data(wr_data),
        .tod(tod), .advanced(advanced)
    );

    owd_alarm_reg u_alarm (
        .clk(clk), .rst_n(rst_n),
        .wr_hr(w_ahr), .wr_mn(w_amn), .wr_sc(w_asc), .wr_data(wr_data),
        .alm(alm), .fields_ok(fields_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= 1'b0;
        else        chk_q <= advanced;
    end

    assign hit = chk_q && fields_ok && (tod == alm);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ALM_OFF, ALM_ARMED, ALM_FIRE: begin
                if (hit)            state_nxt = ALM_FIRE;
                else if (fields_ok) state_nxt = ALM_ARMED;
                else                state_nxt = ALM_OFF;
            end
            default: state_nxt = ALM_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ALM_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        alarm_evt = 1'b0;
        unique case (state)
            ALM_FIRE:          alarm_evt = 1'b1;
            ALM_OFF, ALM_ARMED: alarm_evt = 1'b0;
            default:           alarm_evt = 1'b0;
        endcase
    end

    assign watch_hr    = tod.hr;
    assign watch_min   = tod.mn;
    assign watch_sec   = tod.sc;
    assign alarm_hr    = alm.hr;
    assign alarm_min   = alm.mn;
    assign alarm_sec   = alm.sc;
    assign alarm_armed = fields_ok;

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> !alarm_evt); // R8
    AST_EVT_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> $past(chk_q)); // R8
    AST_EVT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> $past(fields_ok)); // R7
endmodule

// File: tb/owd_watch_test.sv
`timescale 1ns/1ps
module owd_watch_test;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic base_tick = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] watch_hr, alarm_hr;
    logic [5:0] watch_min, watch_sec, alarm_min, alarm_sec;
    logic alarm_armed, alarm_evt;

    int checks = 0;
    int errors = 0;
    int evcnt = 0;
    bit done = 0;

    int m_hr = 0, m_mn = 0, m_sc = 0;
    int a_hr = 31, a_mn = 63, a_sc = 63;
    int pc = 0;
    bit m_chk = 0, m_evt = 0;

    always #2.5 clk = ~clk;

    owd_watch #(.TICKS_PER_SEC(N)) uut (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .watch_hr(watch_hr), .watch_min(watch_min), .watch_sec(watch_sec),
        .alarm_hr(alarm_hr), .alarm_min(alarm_min), .alarm_sec(alarm_sec),
        .alarm_armed(alarm_armed), .alarm_evt(alarm_evt)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hr = 0; m_mn = 0; m_sc = 0;
            a_hr = 31; a_mn = 63; a_sc = 63;
            pc = 0; m_chk = 0; m_evt = 0;
        end else begin
            bit ww, step, ok, nevt;
            int v;
            ww   = wr_en && (wr_addr >= 5);
            step = base_tick && (pc == N - 1);
            ok   = (a_hr <= 23) && (a_mn <= 59) && (a_sc <= 59);
            nevt = m_chk && ok && (m_hr == a_hr) && (m_mn == a_mn) && (m_sc == a_sc);
            m_chk = step && !ww;
            if (wr_en && wr_addr == 7) pc = 0;
            else if (base_tick) pc = step ? 0 : pc + 1;
            if (ww) begin
                if (wr_addr == 5) begin v = wr_data % 32; m_hr = (v > 23) ? 23 : v; end
                if (wr_addr == 6) m_mn = wr_data % 64;
                if (wr_addr == 7) m_sc = wr_data % 64;
            end else if (step) begin
                if (m_sc >= 59) begin
                    m_sc = 0;
                    if (m_mn >= 59) begin
                        m_mn = 0;
                        m_hr = (m_hr >= 23) ? 0 : m_hr + 1;
                    end else m_mn = m_mn + 1;
                end else m_sc = m_sc + 1;
            end
            if (wr_en && wr_addr == 2) a_hr = wr_data % 32;
            if (wr_en && wr_addr == 3) a_mn = wr_data % 64;
            if (wr_en && wr_addr == 4) a_sc = wr_data % 64;
            m_evt = nevt;
        end
    end

    // lockstep comparison every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3", "watch hours", watch_hr, m_hr);
            chk("R3", "watch minutes", watch_min, m_mn);
            chk("R2", "watch seconds", watch_sec, m_sc);
            chk("R6", "alarm hours", alarm_hr, a_hr);
            chk("R6", "alarm minutes", alarm_min, a_mn);
            chk("R6", "alarm seconds", alarm_sec, a_sc);
            chk("R7", "armed", alarm_armed, (a_hr <= 23 && a_mn <= 59 && a_sc <= 59) ? 1 : 0);
            chk("R8", "event", alarm_evt, m_evt);
            if (alarm_evt) evcnt++;
        end
    end

    task automatic run(int n, bit tk);
        for (int i = 0; i < n; i++) begin
            base_tick = tk;
            @(negedge clk);
        end
        base_tick = 1'b0;
    endtask

    task automatic wr(int adr, int dat);
        wr_en = 1'b1; wr_addr = 3'(adr); wr_data = 8'(dat);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        chk("R1", "reset watch", {watch_hr, watch_min, watch_sec}, 0);
        chk("R1", "reset alarm hours", alarm_hr, 31);
        chk("R1", "reset alarm minutes", alarm_min, 63);
        chk("R1", "reset alarm seconds", alarm_sec, 63);
        chk("R1", "reset armed", alarm_armed, 0);
        chk("R1", "reset event", alarm_evt, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(3 * N, 1'b1);
        chk("R2", "seconds after 3 periods", watch_sec, 3);

        wr(6, 70);  chk("R4", "watch minutes 70", watch_min, 6);
        wr(7, 81);  chk("R4", "watch seconds 81", watch_sec, 17);
        wr(5, 25);  chk("R5", "watch hours clamp", watch_hr, 23);
        wr(2, 25);  chk("R5", "alarm hours raw", alarm_hr, 25);
        chk("R7", "armed with hours 25", alarm_armed, 0);
        wr(0, 9); wr(1, 9);
        chk("R6", "addr 0/1 ignored watch", {watch_hr, watch_min, watch_sec}, {5'd23, 6'd6, 6'd17});
        chk("R6", "addr 0/1 ignored alarm", {alarm_hr, alarm_min, alarm_sec}, {5'd25, 6'd63, 6'd63});

        wr(5, 23); wr(6, 59); wr(7, 58);
        run(N, 1'b1);
        chk("R3", "23:59:59", {watch_hr, watch_min, watch_sec}, {5'd23, 6'd59, 6'd59});
        run(N, 1'b1);
        chk("R3", "midnight wrap", {watch_hr, watch_min, watch_sec}, 0);
        wr(6, 63); wr(7, 59);
        run(N, 1'b1);
        chk("R3", "minutes 63 carry", {watch_hr, watch_min, watch_sec}, {5'd1, 6'd0, 6'd0});

        wr(2, 1); wr(3, 0); wr(4, 2);
        chk("R7", "armed at 01:00:02", alarm_armed, 1);
        e0 = evcnt;
        run(3 * N, 1'b1);
        chk("R8", "one event per match", evcnt - e0, 1);

        e0 = evcnt;
        wr(7, 2);
        run(3, 1'b0);
        chk("R9", "written match no event", evcnt - e0, 0);

        wr(3, 60);
        chk("R7", "minutes 60 disarms", alarm_armed, 0);
        wr(3, 0);

        run(2, 1'b1);
        wr(7, 10);
        run(N - 1, 1'b1);
        chk("R10", "held after clear", watch_sec, 10);
        run(1, 1'b1);
        chk("R10", "step after full period", watch_sec, 11);

        run(5, 1'b0);
        finish_run();
    end
endmodule